// File: doc/BRIEF.md
# Instruction Dispatch Grouper with Alone-Only Rule

This block looks at the first four entries of an instruction buffer in each cycle. From them it builds the group that issues in that cycle. It raises one dispatch-valid bit per slot for the instructions that go out, and it reports how many entries the buffer must pop. The buffer supplies the 32-bit SPARC V9 instruction words and a count of how many of them are valid. A stall input holds the whole group back.

Each slot has a decoder that marks instructions the pipeline can only accept with nothing beside them:

- doubleword integer memory operations
- block loads, chosen by their immediate ASI
- carry arithmetic
- conditional moves
- register-window operations
- multiply and divide
- atomics
- state-register access
- traps and flushes
- a few graphics and control operations

A marked instruction at the head goes out alone. A marked instruction in a later slot closes the group just before itself. The block also finds a control transfer that sits in the delay slot of another control transfer, and treats that second one as marked. It does this inside one group and, through a registered flag, across a cycle boundary. Grouping by resource class is not part of this block.

Top module: `dispatch_grouper`

## Requirements
- R1: Instruction words with op=3 and op3 equal to 0x03, 0x13, 0x07 or 0x17 (doubleword integer loads and stores) are alone-only.
- R2: With op=3, op3=0x33 and the immediate-ASI form (bit 13 clear), the word is alone-only when the ASI in bits 12:5 is 0x70, 0x71, 0x78, 0x79, 0xF0, 0xF1, 0xF8 or 0xF9. Other ASIs, and the register-ASI form (bit 13 set), are not alone-only.
- R3: Words with op=2 are alone-only in these cases: op3 is 0x08, 0x18, 0x0C, 0x1C, 0x2C, 0x2F, 0x3C, 0x3D or 0x31; or op3 is 0x35 with opf (bits 13:5) outside 0x050..0x05F. Those opf values are FP compares and are not alone-only.
- R4: Words with op=2 and op3 in {0x09,0x0A,0x0B,0x1A,0x1B,0x24,0x0D,0x0E,0x0F,0x1E,0x1F,0x2D} are alone-only. So are words with op=3 and op3 in {0x0D,0x1D,0x0F,0x1F,0x3C,0x3E}.
- R5: These words are alone-only:
  - op=3 with op3 0x21 or 0x25;
  - op=2 with op3 in {0x3B,0x2B,0x39,0x3E,0x30,0x32,0x28,0x2A,0x3A};
  - op=2 with op3=0x36 and opf 0x018, 0x01A or 0x080.
  A plain ADD (op=2, op3=0x00) is not alone-only.
- R6: When the instruction in slot 0 is alone-only, only slot 0 is dispatched.
- R7: Otherwise the group holds every valid slot before the first alone-only slot, at most four.
- R8: Control transfers are op=1, op=0 with op2 in {1,2,3,5,6}, and op=2 with op3 0x38 or 0x39. A control transfer directly after another control transfer in the same group is treated as alone-only.
- R9: A registered flag records whether the last dispatched instruction was a control transfer. If it is set, a control transfer in slot 0 goes out alone. Cycles that dispatch nothing leave the flag unchanged.
- R10: Nothing is dispatched and the pop count is 0 when the valid count is 0 or the stall input is high.
- R11: Dispatch valids are contiguous from slot 0 and never exceed the valid count. The pop count equals the number of set valids.
- R12: After reset the control-transfer flag is clear, so a control transfer in slot 0 may group with the slots that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 128 | Four instruction words, slot 0 in bits 31:0 |
| cnt_i | input | 3 | Number of valid words from slot 0 (0 to 4) |
| stall_i | input | 1 | Hold dispatch this cycle |
| disp_vld_o | output | 4 | Per-slot dispatch valid |
| pop_o | output | 3 | Number of entries to pop |

## Verification
The decode cut and the delay-slot couple cut can both shorten the same group, and the couple cut can come from the flag held over from an earlier cycle. The sweep walks every arrangement of eight instruction kinds over four slots. The kinds include branches, calls, jumps, alone-only loads and a look-alike block load with a different ASI. The sweep also varies the valid count and inserts stalls, so the inter-cycle flag is tested both across stalls and against the cuts within a group. A bench model applies the rules to per-kind attributes, and its group length and valid mask are compared with the ports in every cycle.

// File: rtl/dg_pkg.sv
package dg_pkg;
  localparam int unsigned IW = 32;

  typedef struct packed {
    logic solo;
    logic cti;
  } dg_dec_t;
endpackage

// File: rtl/dg_decode.sv
module dg_decode
  import dg_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dg_dec_t       dec_o
);
  logic [1:0] op;
  logic [2:0] op2;
  logic [5:0] op3;
  logic       imm;
  logic [7:0] asi;
  logic [8:0] opf;
  logic       unused_bits;

  assign op  = instr_i[31:30];
  assign op2 = instr_i[24:22];
  assign op3 = instr_i[24:19];
  assign imm = instr_i[13];
  assign asi = instr_i[12:5];
  assign opf = instr_i[13:5];
  assign unused_bits = ^{instr_i[29:25], instr_i[18:14], instr_i[4:0]};

  always_comb begin
    dec_o = '0;
    unique case (op)
      2'b00: dec_o.cti = (op2 inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6});
      2'b01: dec_o.cti = 1'b1;
      2'b10: begin
        case (op3)
          // carry arith, moves, window ops
          6'h08, 6'h18, 6'h0C, 6'h1C, 6'h2C, 6'h2F, 6'h3C, 6'h3D, 6'h31,
          // multiply / divide
          6'h09, 6'h0A, 6'h0B, 6'h1A, 6'h1B, 6'h24, 6'h0D, 6'h0E, 6'h0F,
          6'h1E, 6'h1F, 6'h2D,
          // flush, done/retry, state register access, trap
          6'h3B, 6'h2B, 6'h3E, 6'h30, 6'h32, 6'h28, 6'h2A, 6'h3A:
            dec_o.solo = 1'b1;
          6'h38: dec_o.cti = 1'b1;
          6'h39: begin
            dec_o.solo = 1'b1;
            dec_o.cti  = 1'b1;
          end
          // FP move space, compares excluded
          6'h35: dec_o.solo = (opf[8:4] != 5'h05);
          6'h36: dec_o.solo = (opf inside {9'h018, 9'h01A, 9'h080});
          default: dec_o = '0;
        endcase
      end
      default: begin
        case (op3)
          6'h03, 6'h13, 6'h07, 6'h17,
          6'h0D, 6'h1D, 6'h0F, 6'h1F, 6'h3C, 6'h3E,
          6'h21, 6'h25:
            dec_o.solo = 1'b1;
          // block-load ASIs: x111_x00x
          6'h33: dec_o.solo = !imm && ((asi & 8'h76) == 8'h70);
          default: dec_o = '0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/dg_select.sv
module dg_select #(
  parameter int unsigned LANES = 4,
  localparam int unsigned CNTW = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] solo_i,
  input  logic [LANES-1:0] cti_i,
  input  logic             prev_cti_i,
  input  logic [CNTW-1:0]  cnt_i,
  input  logic             stall_i,
  output logic [LANES-1:0] vld_o,
  output logic [CNTW-1:0]  pop_o,
  output logic             last_cti_o
);
  logic [LANES-1:0] cut;
  logic             go;
  logic [CNTW-1:0]  n;

  for (genvar k = 0; k < LANES; k++) begin : g_cut
    if (k == 0) begin : g_head
      assign cut[k] = solo_i[k] | (cti_i[k] & prev_cti_i);
    end else begin : g_tail
      assign cut[k] = solo_i[k] | (cti_i[k] & cti_i[k-1]);
    end
  end

  assign go = !stall_i && (cnt_i != '0);

  always_comb begin
    n = '0;
    if (go) begin
      n = CNTW'(1);
      if (!cut[0]) begin
        for (int k = 1; k < LANES; k++) begin
          if (n == CNTW'(k) && CNTW'(k) < cnt_i && !cut[k]) n = CNTW'(k + 1);
        end
      end
    end
  end

  always_comb begin
    last_cti_o = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      vld_o[k] = CNTW'(k) < n;
      if (n == CNTW'(k + 1)) last_cti_o = cti_i[k];
    end
  end

  assign pop_o = n;

  p_head_alone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && solo_i[0]) |-> (vld_o == LANES'(1)));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i || cnt_i == '0) |-> (vld_o == '0));
  p_contig_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vld_o + LANES'(1)) & vld_o) == '0);
  p_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o <= cnt_i);
endmodule

// File: rtl/dg_couple_trk.sv
module dg_couple_trk #(
  parameter int unsigned CNTW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CNTW-1:0] pop_i,
  input  logic            last_cti_i,
  output logic            prev_cti_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              prev_q <= 1'b0;
    else if (pop_i != '0)     prev_q <= last_cti_i;
  end

  assign prev_cti_o = prev_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i == '0) |=> $stable(prev_cti_o));
endmodule

// File: rtl/dispatch_grouper.sv
module dispatch_grouper
  import dg_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned CNTW = $clog2(LANES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*IW-1:0] instr_i,
  input  logic [CNTW-1:0]     cnt_i,
  input  logic                stall_i,
  output logic [LANES-1:0]    disp_vld_o,
  output logic [CNTW-1:0]     pop_o
);
  logic [LANES-1:0] solo;
  logic [LANES-1:0] cti;
  logic             prev_cti;
  logic             last_cti;

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    dg_dec_t d;
    dg_decode u_dec (
      .instr_i (instr_i[k*IW +: IW]),
      .dec_o   (d)
    );
    assign solo[k] = d.solo;
    assign cti[k]  = d.cti;
  end

  dg_select #(.LANES(LANES)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .solo_i     (solo),
    .cti_i      (cti),
    .prev_cti_i (prev_cti),
    .cnt_i      (cnt_i),
    .stall_i    (stall_i),
    .vld_o      (disp_vld_o),
    .pop_o      (pop_o),
    .last_cti_o (last_cti)
  );

  dg_couple_trk #(.CNTW(CNTW)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (pop_o),
    .last_cti_i (last_cti),
    .prev_cti_o (prev_cti)
  );

  p_pop_count_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(disp_vld_o) == int'(pop_o));
  p_couple_cross_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_cti && cti[0] && pop_o != '0) |-> (pop_o == CNTW'(1)));
endmodule

// File: tb/dispatch_grouper_bench.sv
`timescale 1ns/1ps
module dispatch_grouper_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] instr = '0;
  logic [2:0]   cnt = '0;
  logic         stall = 1'b0;
  logic [3:0]   vld;
  logic [2:0]   pop;

  int errors = 0;
  int checks = 0;
  bit mprev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dispatch_grouper u_dispatch_grouper (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .cnt_i(cnt),
    .stall_i(stall), .disp_vld_o(vld), .pop_o(pop)
  );

  function automatic logic [31:0] f3(input logic [1:0] op, input logic [5:0] op3,
                                     input logic [13:0] lo);
    return {op, 5'd1, op3, 5'd2, lo};
  endfunction
  function automatic logic [31:0] fop(input logic [5:0] op3, input logic [8:0] opf);
    return f3(2'd2, op3, {opf, 5'd3});
  endfunction
  function automatic logic [31:0] bld(input logic [7:0] asi);
    return f3(2'd3, 6'h33, {1'b0, asi, 5'd4});
  endfunction

  localparam logic [31:0] W_ADD  = 32'h8200_8003; // op=2 op3=0
  localparam logic [31:0] W_BR   = {2'b00, 5'd8, 3'd2, 22'h10};
  localparam logic [31:0] W_CALL = {2'b01, 30'h40};

  task automatic step(input logic [31:0] w0, w1, w2, w3, input logic [3:0] so,
                      input logic [3:0] ct, input int c, input bit stl, input string tag);
    int n;
    logic [3:0] s;
    logic [3:0] ev;
    @(negedge clk);
    instr = {w3, w2, w1, w0};
    cnt   = 3'(c);
    stall = stl;
    #1;
    for (int k = 0; k < 4; k++)
      s[k] = so[k] | (ct[k] & ((k == 0) ? mprev : ct[k-1]));
    n = 0;
    if (!stl && c > 0) begin
      n = 1;
      if (!s[0]) while (n < c && n < 4 && !s[n]) n++;
    end
    ev = 4'((1 << n) - 1);
    checks++;
    if (int'(pop) != n || vld !== ev) begin
      errors++;
      $display("FAIL %s: pop=%0d vld=%b expected pop=%0d vld=%b", tag, pop, vld, n, ev);
    end
    if (n > 0) mprev = ct[n-1];
  endtask

  // alone-only word at slot 1 then at slot 0
  task automatic alone(input logic [31:0] w, input bit c, input string tag);
    step(W_ADD, w, W_ADD, W_ADD, 4'b0010, {2'b00, c, 1'b0}, 4, 1'b0, tag);
    step(w, W_ADD, W_ADD, W_ADD, 4'b0001, {3'b000, c}, 4, 1'b0, tag);
    step(W_ADD, W_ADD, W_ADD, W_ADD, 4'b0000, 4'b0000, 4, 1'b0, tag);
  endtask

  logic [31:0] pool [8];
  logic [7:0]  p_so, p_ct;

  initial begin
    pool[0] = W_ADD;                 // plain
    pool[1] = {2'b00, 5'd0, 3'd4, 22'h1}; // sethi, plain
    pool[2] = W_BR;                  // cti
    pool[3] = W_CALL;                // cti
    pool[4] = f3(2'd3, 6'h03, 14'd0); // alone
    pool[5] = bld(8'h79);            // alone
    pool[6] = bld(8'h7A);            // plain
    pool[7] = f3(2'd2, 6'h38, 14'd0); // cti
    p_so = 8'b0011_0000;
    p_ct = 8'b1000_1100;

    #1;
    checks++;
    if (pop !== 3'd0 || vld !== 4'd0) begin
      errors++;
      $display("FAIL R12: in reset pop=%0d vld=%b expected pop=0 vld=0000", pop, vld);
    end
    #10 rst_n = 1'b1;

    // R12: flag clear, branch at head groups with followers
    step(W_BR, W_ADD, W_ADD, W_ADD, 4'b0000, 4'b0001, 4, 1'b0, "R12");
    // R10
    step(W_ADD, W_ADD, W_ADD, W_ADD, 4'b0000, 4'b0000, 0, 1'b0, "R10");
    step(W_ADD, W_ADD, W_ADD, W_ADD, 4'b0000, 4'b0000, 4, 1'b1, "R10");

    // R1
    alone(f3(2'd3, 6'h03, 0), 0, "R1");  alone(f3(2'd3, 6'h13, 0), 0, "R1");
    alone(f3(2'd3, 6'h07, 0), 0, "R1");  alone(f3(2'd3, 6'h17, 0), 0, "R1");
    // R2
    alone(bld(8'h70), 0, "R2"); alone(bld(8'h71), 0, "R2"); alone(bld(8'h78), 0, "R2");
    alone(bld(8'h79), 0, "R2"); alone(bld(8'hF0), 0, "R2"); alone(bld(8'hF1), 0, "R2");
    alone(bld(8'hF8), 0, "R2"); alone(bld(8'hF9), 0, "R2");
    step(bld(8'h72), bld(8'h80), f3(2'd3, 6'h33, 14'h2E00), W_ADD, 4'b0000, 4'b0000, 4, 1'b0, "R2");
    // R3
    alone(f3(2'd2, 6'h08, 0), 0, "R3"); alone(f3(2'd2, 6'h18, 0), 0, "R3");
    alone(f3(2'd2, 6'h0C, 0), 0, "R3"); alone(f3(2'd2, 6'h1C, 0), 0, "R3");
    alone(f3(2'd2, 6'h2C, 0), 0, "R3"); alone(f3(2'd2, 6'h2F, 0), 0, "R3");
    alone(fop(6'h35, 9'h001), 0, "R3"); alone(fop(6'h35, 9'h025), 0, "R3");
    alone(f3(2'd2, 6'h3C, 0), 0, "R3"); alone(f3(2'd2, 6'h3D, 0), 0, "R3");
    alone(f3(2'd2, 6'h31, 0), 0, "R3");
    step(fop(6'h35, 9'h051), fop(6'h35, 9'h056), W_ADD, W_ADD, 4'b0000, 4'b0000, 4, 1'b0, "R3");
    // R4
    alone(f3(2'd2, 6'h09, 0), 0, "R4"); alone(f3(2'd2, 6'h0A, 0), 0, "R4");
    alone(f3(2'd2, 6'h0B, 0), 0, "R4"); alone(f3(2'd2, 6'h1A, 0), 0, "R4");
    alone(f3(2'd2, 6'h1B, 0), 0, "R4"); alone(f3(2'd2, 6'h24, 0), 0, "R4");
    alone(f3(2'd2, 6'h0D, 0), 0, "R4"); alone(f3(2'd2, 6'h0E, 0), 0, "R4");
    alone(f3(2'd2, 6'h0F, 0), 0, "R4"); alone(f3(2'd2, 6'h1E, 0), 0, "R4");
    alone(f3(2'd2, 6'h1F, 0), 0, "R4"); alone(f3(2'd2, 6'h2D, 0), 0, "R4");
    alone(f3(2'd3, 6'h0D, 0), 0, "R4"); alone(f3(2'd3, 6'h1D, 0), 0, "R4");
    alone(f3(2'd3, 6'h0F, 0), 0, "R4"); alone(f3(2'd3, 6'h1F, 0), 0, "R4");
    alone(f3(2'd3, 6'h3C, 0), 0, "R4"); alone(f3(2'd3, 6'h3E, 0), 0, "R4");
    // R5
    alone(f3(2'd3, 6'h21, 0), 0, "R5"); alone(f3(2'd3, 6'h25, 0), 0, "R5");
    alone(f3(2'd2, 6'h3B, 0), 0, "R5"); alone(f3(2'd2, 6'h2B, 0), 0, "R5");
    alone(f3(2'd2, 6'h39, 0), 1, "R5"); alone(f3(2'd2, 6'h3E, 0), 0, "R5");
    alone(f3(2'd2, 6'h30, 0), 0, "R5"); alone(f3(2'd2, 6'h32, 0), 0, "R5");
    alone(f3(2'd2, 6'h28, 0), 0, "R5"); alone(f3(2'd2, 6'h2A, 0), 0, "R5");
    alone(f3(2'd2, 6'h3A, 0), 0, "R5");
    alone(fop(6'h36, 9'h018), 0, "R5"); alone(fop(6'h36, 9'h01A), 0, "R5");
    alone(fop(6'h36, 9'h080), 0, "R5");
    step(W_ADD, fop(6'h36, 9'h019), W_ADD, W_ADD, 4'b0000, 4'b0000, 4, 1'b0, "R5");

    // R8: couple inside a group
    step(W_ADD, W_BR, W_CALL, W_ADD, 4'b0000, 4'b0110, 4, 1'b0, "R8");
    // R9: flag survives a stall, then isolates the head branch
    step(W_BR, W_BR, W_ADD, W_ADD, 4'b0000, 4'b0011, 1, 1'b0, "R9");
    step(W_BR, W_ADD, W_ADD, W_ADD, 4'b0000, 4'b0001, 4, 1'b1, "R9");
    step(W_BR, W_ADD, W_ADD, W_ADD, 4'b0000, 4'b0001, 4, 1'b0, "R9");

    // R6 R7 R8 R9 R10 R11: sweep of kinds over four slots
    for (int idx = 0; idx < 4096; idx++) begin
      logic [2:0] k0, k1, k2, k3;
      k0 = 3'(idx); k1 = 3'(idx >> 3); k2 = 3'(idx >> 6); k3 = 3'(idx >> 9);
      step(pool[k0], pool[k1], pool[k2], pool[k3],
           {p_so[k3], p_so[k2], p_so[k1], p_so[k0]},
           {p_ct[k3], p_ct[k2], p_ct[k1], p_ct[k0]},
           idx % 5, (idx % 11) == 10, "R6 R7 R8 R9 R10 R11 sweep");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule